// File: doc/BRIEF.md
# Multifunction ALU with Upper-Immediate Placement

This block is the combinational execute-stage ALU of a small 32-bit load/store processor. Two operands and a compact control word select one of four result classes: upper-immediate placement, signed set-less-than, add/subtract, and a four-way bitwise logic unit. A single adder/subtractor serves both the arithmetic class and the signed comparison. The comparison takes the sign of the difference, corrected for overflow, rather than using a separate comparator.

The control word carries a 2-bit class selector, an add/subtract bit, a 2-bit logic selector and a 3-bit shift field. The shift field is reserved and this version ignores it. The block also drives a zero flag taken from the adder output, which the next-address logic uses to resolve equal and not-equal branches. The block has no clock and no state. Its outputs follow its inputs within one combinational path.

Top module: `mf_alu`

## Requirements
- R1: With `fn_class` = 0 (upper immediate), `result` = {`upper_imm`, 16 zero bits}, and the operands have no effect on it.
- R2: With `fn_class` = 2 and `sub_en` = 0, `result` = `opnd_a` + `opnd_b` modulo 2^32.
- R3: With `fn_class` = 2 and `sub_en` = 1, `result` = `opnd_a` - `opnd_b` modulo 2^32.
- R4: With `fn_class` = 1 (set-less), `result` is 1 when `opnd_a` < `opnd_b` as two's-complement signed numbers and 0 otherwise, whatever the value of `sub_en`. This holds when the difference overflows.
- R5: With `fn_class` = 3, `logic_sel` picks 0 = AND, 1 = OR, 2 = XOR, 3 = NOR of the two operands.
- R6: `zero` is 1 exactly when the adder output is all zeros. The adder subtracts when `sub_en` = 1 or `fn_class` = 1, and adds otherwise. This applies in every class.
- R7: `shift_ctl` has no effect on either output.
- R8: `upper_imm` has no effect on either output when `fn_class` is 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| fn_class | input | 2 | Result class: 0 upper-imm, 1 set-less, 2 arithmetic, 3 logic |
| sub_en | input | 1 | 0 add, 1 subtract (arithmetic class) |
| logic_sel | input | 2 | 0 AND, 1 OR, 2 XOR, 3 NOR |
| shift_ctl | input | 3 | Reserved shift control, ignored |
| upper_imm | input | 16 | Immediate placed in the upper half by class 0 |
| result | output | 32 | Selected result |
| zero | output | 1 | Adder output is all zeros |

## Verification
The adder drives two outputs at once: the zero flag and, in the set-less class, the comparison. Operand pairs that make the difference zero, or make it overflow, are swept with every class and both settings of `sub_en`. The zero flag must follow the forced subtraction in the set-less class. The comparison must take the overflow-corrected sign and not the raw sign bit. The bench also varies the shift field and the immediate on every vector, and the judgement is that neither one changes either output.

// File: rtl/mf_alu_pkg.sv
package mf_alu_pkg;
    typedef enum logic [1:0] {
        CLS_UPPER = 2'd0,
        CLS_SLESS = 2'd1,
        CLS_ARITH = 2'd2,
        CLS_LOGIC = 2'd3
    } alu_class_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'd0,
        LOP_OR  = 2'd1,
        LOP_XOR = 2'd2,
        LOP_NOR = 2'd3
    } logic_op_e;
endpackage

// File: rtl/mf_alu_addsub.sv
module mf_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum_out,
    output logic             ovf_out,
    output logic             less_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             carry_unused;

    // Subtract as a + ~b + 1 so one carry chain serves both operations
    assign b_eff = do_sub ? ~b_in : b_in;
    assign {carry_unused, sum_out} = {1'b0, a_in} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};

    // Overflow: inputs share a sign that the sum does not
    assign ovf_out  = (a_in[MSB] == b_eff[MSB]) && (sum_out[MSB] != a_in[MSB]);
    // Signed less-than is the true sign of a-b
    assign less_out = sum_out[MSB] ^ ovf_out;
endmodule

// File: rtl/mf_alu_logic.sv
module mf_alu_logic
    import mf_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] y_out
);
    logic_op_e op_e;
    assign op_e = logic_op_e'(op_sel);

    always_comb begin
        unique case (op_e)
            LOP_AND: y_out = a_in & b_in;
            LOP_OR:  y_out = a_in | b_in;
            LOP_XOR: y_out = a_in ^ b_in;
            LOP_NOR: y_out = ~(a_in | b_in);
            default: y_out = '0;
        endcase
    end
endmodule

// File: rtl/mf_alu_upper.sv
module mf_alu_upper #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm_in,
    output logic [WIDTH-1:0] y_out
);
    localparam int LOW_W = WIDTH - IMM_W;

    generate
        if (LOW_W > 0) begin : g_pad
            assign y_out = {imm_in, {LOW_W{1'b0}}};
        end else begin : g_full
            assign y_out = imm_in[IMM_W-1 -: WIDTH];
        end
    endgenerate
endmodule

// File: rtl/mf_alu.sv
module mf_alu
    import mf_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int IMM_W   = 16,
    parameter int SHIFT_W = 3
) (
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic [1:0]         fn_class,
    input  logic               sub_en,
    input  logic [1:0]         logic_sel,
    input  logic [SHIFT_W-1:0] shift_ctl,
    input  logic [IMM_W-1:0]   upper_imm,
    output logic [WIDTH-1:0]   result,
    output logic               zero
);
    alu_class_e       cls_e;
    logic             adder_sub;
    logic [WIDTH-1:0] sum_w;
    logic             ovf_w;
    logic             less_w;
    logic [WIDTH-1:0] logic_w;
    logic [WIDTH-1:0] upper_w;
    logic             shift_unused;

    assign cls_e        = alu_class_e'(fn_class);
    assign shift_unused = ^shift_ctl;

    // Set-less forces the shared adder into subtract mode
    assign adder_sub = sub_en | (cls_e == CLS_SLESS);

    mf_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_in     (opnd_a),
        .b_in     (opnd_b),
        .do_sub   (adder_sub),
        .sum_out  (sum_w),
        .ovf_out  (ovf_w),
        .less_out (less_w)
    );

    mf_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_in   (opnd_a),
        .b_in   (opnd_b),
        .op_sel (logic_sel),
        .y_out  (logic_w)
    );

    mf_alu_upper #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_upper (
        .imm_in (upper_imm),
        .y_out  (upper_w)
    );

    always_comb begin
        unique case (cls_e)
            CLS_UPPER: result = upper_w;
            CLS_SLESS: result = {{(WIDTH-1){1'b0}}, less_w};
            CLS_ARITH: result = sum_w;
            CLS_LOGIC: result = logic_w;
            default:   result = '0;
        endcase
    end

    assign zero = ~|sum_w;
endmodule

// File: rtl/mf_alu_chk.sv
module mf_alu_chk #(
    parameter int WIDTH   = 32,
    parameter int IMM_W   = 16,
    parameter int SHIFT_W = 3
) (
    input logic [WIDTH-1:0]   opnd_a,
    input logic [WIDTH-1:0]   opnd_b,
    input logic [1:0]         fn_class,
    input logic               sub_en,
    input logic [1:0]         logic_sel,
    input logic [SHIFT_W-1:0] shift_ctl,
    input logic [IMM_W-1:0]   upper_imm,
    input logic [WIDTH-1:0]   result,
    input logic               zero
);
    localparam int LOW_W = WIDTH - IMM_W;

    logic known;
    assign known = !$isunknown({opnd_a, opnd_b, fn_class, sub_en, logic_sel, upper_imm, result, zero});

    always_comb begin
        if (known) begin
            if (fn_class == 2'd0)
                AST_UPPER_LOW_CLEAR: assert (result[LOW_W-1:0] == '0); // R1
            if (fn_class == 2'd2 && !sub_en)
                AST_SUM_INVERTS: assert (result - opnd_b == opnd_a); // R2
            if (fn_class == 2'd2 && sub_en)
                AST_DIFF_INVERTS: assert (result + opnd_b == opnd_a); // R3
            if (fn_class == 2'd1)
                AST_SLESS_MATCHES: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))}); // R4
            if (fn_class == 2'd3 && logic_sel == 2'd3)
                AST_NOR_COMPLEMENT: assert ((result ^ (opnd_a | opnd_b)) == '1); // R5
            if (fn_class == 2'd1 || (fn_class == 2'd2 && sub_en))
                AST_ZERO_ON_EQUAL: assert (zero == (opnd_a == opnd_b)); // R6
        end
    end
endmodule

bind mf_alu mf_alu_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W), .SHIFT_W(SHIFT_W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .fn_class  (fn_class),
    .sub_en    (sub_en),
    .logic_sel (logic_sel),
    .shift_ctl (shift_ctl),
    .upper_imm (upper_imm),
    .result    (result),
    .zero      (zero)
);

// File: tb/sim_mf_alu.sv
module sim_mf_alu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  fn_class = '0;
    logic        sub_en = 1'b0;
    logic [1:0]  logic_sel = '0;
    logic [2:0]  shift_ctl = '0;
    logic [15:0] upper_imm = '0;
    logic [31:0] result;
    logic        zero;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    mf_alu u0 (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .fn_class(fn_class), .sub_en(sub_en),
        .logic_sel(logic_sel), .shift_ctl(shift_ctl), .upper_imm(upper_imm),
        .result(result), .zero(zero)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [31:0] corner(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h8000_0001;
            6: return 32'h1234_5678;
            default: return 32'hFFFF_0000;
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] a, input logic [31:0] b,
                               input logic [1:0] cls, input logic sb,
                               input logic [1:0] ls, input logic [2:0] sh,
                               input logic [15:0] im);
        logic [31:0] exp_r;
        logic        exp_z;
        logic [31:0] adder;
        string       tag;
        @(negedge clk);
        opnd_a = a; opnd_b = b; fn_class = cls; sub_en = sb;
        logic_sel = ls; shift_ctl = sh; upper_imm = im;
        adder = (sb || cls == 2'd1) ? a - b : a + b;
        exp_z = (adder == 32'h0);
        case (cls)
            2'd0: begin exp_r = {im, 16'h0000}; tag = "R1"; end
            2'd1: begin exp_r = ($signed(a) < $signed(b)) ? 32'h1 : 32'h0; tag = "R4"; end
            2'd2: begin exp_r = sb ? a - b : a + b; tag = sb ? "R3" : "R2"; end
            default: begin
                case (ls)
                    2'd0: exp_r = a & b;
                    2'd1: exp_r = a | b;
                    2'd2: exp_r = a ^ b;
                    default: exp_r = ~(a | b);
                endcase
                tag = "R5";
            end
        endcase
        @(posedge clk);
        #1;
        n_cmp++;
        if (result !== exp_r) begin
            n_bad++;
            $display("FAIL %s/R7/R8 result cls=%0d sub=%0d ls=%0d sh=%0d: actual %h expected %h",
                     tag, cls, sb, ls, sh, result, exp_r);
        end
        n_cmp++;
        if (zero !== exp_z) begin
            n_bad++;
            $display("FAIL R6/R7 zero cls=%0d sub=%0d a=%h b=%h: actual %b expected %b",
                     cls, sb, a, b, zero, exp_z);
        end
    endtask

    task automatic all_ops(input logic [31:0] a, input logic [31:0] b);
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int l = 0; l < 4; l++) begin
                    if (c == 3 || l == 0) begin
                        rng = next_rng(rng);
                        // R7, R8: shift field and immediate vary on every vector
                        apply_check(a, b, 2'(c), 1'(s), 2'(l), rng[2:0], rng[31:16]);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all inputs zero gives result 0 and zero set (R1, R6)
        apply_check(32'h0, 32'h0, 2'd0, 1'b0, 2'd0, 3'd0, 16'h0);
        // R4 overflow corners: min < 1, max > -1, min < max
        apply_check(32'h8000_0000, 32'h0000_0001, 2'd1, 1'b0, 2'd0, 3'd5, 16'hBEEF);
        apply_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd1, 1'b1, 2'd0, 3'd2, 16'h1111);
        apply_check(32'h8000_0000, 32'h7FFF_FFFF, 2'd1, 1'b0, 2'd0, 3'd7, 16'h0);
        // R6: add to zero, subtract equal operands
        apply_check(32'h0000_0001, 32'hFFFF_FFFF, 2'd2, 1'b0, 2'd0, 3'd1, 16'h0);
        apply_check(32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'd3, 1'b1, 2'd2, 3'd3, 16'h5A5A);
        // R1: operands do not affect upper placement
        apply_check(32'hFFFF_FFFF, 32'h1234_5678, 2'd0, 1'b1, 2'd3, 3'd6, 16'hA5C3);
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                all_ops(corner(i), corner(j));
        for (int k = 0; k < 120; k++) begin
            logic [31:0] ra;
            rng = next_rng(rng); ra = rng;
            rng = next_rng(rng);
            all_ops(ra, (k % 5 == 0) ? ra : rng);
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        #2;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule